// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the register number and word address for every transfer of a block load or block store. A one-cycle start pulse captures a base address, a 16-bit register selection mask and two mode bits. One bit chooses whether the address moves before or after each access. The other chooses whether addresses go up or down. The block then issues one selected register per cycle together with its word address. A done flag marks the final transfer. A write-back base value is presented for the address register update.

The next register comes from a two-level priority search. The mask is cut into 4-bit groups. The first occupied group is chosen, and then the first set bit inside that group. When going up, the search favours low indices. When going down, it favours high indices. A working copy of the mask loses each bit as that bit is issued. Bit 15 (the program counter slot) is treated like any other bit.

Top module: `lsm_addr_seq`

## Requirements
- R1: After a synchronous active-high reset, `acc_valid` and `seq_done` are 0 and `wb_base` is 0.
- R2: The mode is {`pre_index`,`up`}. With `up`=1 the selected registers are issued in ascending index order, and with `up`=0 in descending order. Each set bit of `reg_list` is issued exactly once, one per consecutive cycle, with bit 15 included.
- R3: The first transfer appears in the cycle after the clock edge that samples `start`. Its address is the base plus an offset: +0 for {0,1}, +4 for {1,1}, +0 for {0,0}, and -4 for {1,0}.
- R4: Each following transfer address is the previous one plus 4 when `up`=1, or minus 4 when `up`=0, modulo 2^32.
- R5: `seq_done` is high for exactly one cycle, the cycle that issues the last selected register.
- R6: From the done cycle until the next start, `wb_base` equals the base plus 4×N (`up`=1) or minus 4×N (`up`=0), where N is the number of set bits. This equals the last issued address plus +4 for {0,1}, +0 for {1,1}, -4 for {0,0}, and +0 for {1,0}.
- R7: With an all-zero `reg_list`, `seq_done` rises in the cycle after the start edge, `acc_valid` stays 0, and `wb_base` equals the base.
- R8: A `start` pulse is ignored while a sequence is in progress, up to and including its done cycle. The register order, the addresses and `wb_base` of the running sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sequence (sampled only while idle) |
| base_addr | input | 32 | Base address register value |
| reg_list | input | 16 | Register selection mask, bit 15 = program counter |
| pre_index | input | 1 | 1: step before access, 0: step after access |
| up | input | 1 | 1: ascending addresses, 0: descending |
| acc_valid | output | 1 | A transfer is issued this cycle |
| acc_reg | output | 4 | Register index of the current transfer |
| acc_addr | output | 32 | Word address of the current transfer |
| seq_done | output | 1 | Last transfer of the sequence (or empty list) |
| wb_base | output | 32 | Updated base value for write-back |

## Verification
The bench goes after three kinds of corner case. The first is the empty mask, where a design that waits for a first valid would hang or emit a stray transfer. The second is the full mask and single-bit masks at either end, including bit 15 in descending modes. A search that mishandles the top group would issue a wrong or duplicated index there. The third is bases near zero and the top of the address space, where a wrong sign on the pre-decrement offset shows up as an address off by 8. A start pulse injected on the first transfer and on a single-transfer done cycle exposes a sequencer that re-arms early and corrupts the register order or the write-back base.

// File: rtl/lsm_seq_pkg.sv
package lsm_seq_pkg;

  // Offsets are expressed in words; callers scale by the word size.
  function automatic int first_off_words(input logic pre, input logic up);
    if (up) return pre ? 1 : 0;
    else    return pre ? -1 : 0;
  endfunction

  function automatic int end_off_words(input logic pre, input logic up);
    if (pre) return 0;
    else     return up ? 1 : -1;
  endfunction

  function automatic int step_words(input logic up);
    return up ? 1 : -1;
  endfunction

endpackage

// File: rtl/lsm_group_scan.sv
// Finds the lowest and highest set bit of a small vector.
module lsm_group_scan #(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] lo,
  output logic [IW-1:0] hi
);

  assign any = |bits;

  always_comb begin
    lo = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (bits[i]) lo = IW'(i);
    end
  end

  always_comb begin
    hi = '0;
    for (int i = 0; i < W; i++) begin
      if (bits[i]) hi = IW'(i);
    end
  end

endmodule

// File: rtl/lsm_prio_pick.sv
// Two-level priority search: first occupied group, then first bit in it.
module lsm_prio_pick #(
  parameter int LIST_W  = 16,
  parameter int GROUP_W = 4,
  localparam int IDX_W  = $clog2(LIST_W)
) (
  input  logic [LIST_W-1:0] vec,
  input  logic              up,
  output logic              any,
  output logic [IDX_W-1:0]  idx
);

  localparam int NGRP = LIST_W / GROUP_W;
  localparam int GI_W = $clog2(GROUP_W);
  localparam int G_W  = $clog2(NGRP);

  logic [NGRP-1:0]           grp_any;
  logic [NGRP-1:0][GI_W-1:0] grp_lo;
  logic [NGRP-1:0][GI_W-1:0] grp_hi;
  logic [G_W-1:0]            gsel_lo;
  logic [G_W-1:0]            gsel_hi;
  logic [G_W-1:0]            gsel;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    lsm_group_scan #(.W(GROUP_W)) u_scan (
      .bits (vec[g*GROUP_W +: GROUP_W]),
      .any  (grp_any[g]),
      .lo   (grp_lo[g]),
      .hi   (grp_hi[g])
    );
  end

  lsm_group_scan #(.W(NGRP)) u_level (
    .bits (grp_any),
    .any  (any),
    .lo   (gsel_lo),
    .hi   (gsel_hi)
  );

  assign gsel = up ? gsel_lo : gsel_hi;
  assign idx  = {gsel, (up ? grp_lo[gsel] : grp_hi[gsel])};

endmodule

// File: rtl/lsm_addr_gen.sv
// Address arithmetic: first address, next address, write-back value.
module lsm_addr_gen
  import lsm_seq_pkg::*;
#(
  parameter int LIST_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [LIST_W-1:0] list,
  input  logic              pre,
  input  logic              up,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              cur_up,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] wb_calc
);

  int sel_cnt;

  always_comb begin
    sel_cnt = 0;
    for (int i = 0; i < LIST_W; i++) sel_cnt += int'(list[i]);
  end

  assign first_addr = base + ADDR_W'(first_off_words(pre, up) * WORD_BYTES);
  assign next_addr  = cur_addr + ADDR_W'(step_words(cur_up) * WORD_BYTES);
  assign wb_calc    = base + ADDR_W'(sel_cnt * step_words(up) * WORD_BYTES);

endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_seq_pkg::*;
#(
  parameter int LIST_W     = 16,
  parameter int GROUP_W    = 4,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LIST_W-1:0] reg_list,
  input  logic              pre_index,
  input  logic              up,
  output logic              acc_valid,
  output logic [IDX_W-1:0]  acc_reg,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              seq_done,
  output logic [ADDR_W-1:0] wb_base
);

  logic              busy_q;
  logic [LIST_W-1:0] work_q;
  logic [ADDR_W-1:0] addr_q;
  logic              up_q;
  logic              pre_q;
  logic [ADDR_W-1:0] wb_q;

  logic              pick_any;
  logic [IDX_W-1:0]  pick_idx;
  logic [LIST_W-1:0] sel_mask;
  logic [LIST_W-1:0] remain;
  logic              launch;
  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] next_addr;
  logic [ADDR_W-1:0] wb_calc;

  lsm_prio_pick #(.LIST_W(LIST_W), .GROUP_W(GROUP_W)) u_pick (
    .vec (work_q),
    .up  (up_q),
    .any (pick_any),
    .idx (pick_idx)
  );

  lsm_addr_gen #(.LIST_W(LIST_W), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_agen (
    .base       (base_addr),
    .list       (reg_list),
    .pre        (pre_index),
    .up         (up),
    .cur_addr   (addr_q),
    .cur_up     (up_q),
    .first_addr (first_addr),
    .next_addr  (next_addr),
    .wb_calc    (wb_calc)
  );

  // Named internal events
  assign launch   = start && !busy_q;
  assign sel_mask = pick_any ? (LIST_W'(1) << pick_idx) : '0;
  assign remain   = work_q & ~sel_mask;

  assign acc_valid = busy_q && pick_any;
  assign acc_reg   = pick_idx;
  assign acc_addr  = addr_q;
  assign seq_done  = busy_q && (remain == '0);
  assign wb_base   = wb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      work_q <= '0;
      addr_q <= '0;
      up_q   <= 1'b0;
      pre_q  <= 1'b0;
      wb_q   <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      work_q <= reg_list;
      addr_q <= first_addr;
      up_q   <= up;
      pre_q  <= pre_index;
      wb_q   <= wb_calc;
    end else if (busy_q) begin
      work_q <= remain;
      addr_q <= next_addr;
      if (seq_done) busy_q <= 1'b0;
    end
  end

  // Assertions
  assert_issued_bit_set_R2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> work_q[acc_reg]);

  assert_order_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !seq_done) |=>
      (acc_valid && (up_q ? (acc_reg > $past(acc_reg)) : (acc_reg < $past(acc_reg)))));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !seq_done) |=>
      (acc_addr == $past(acc_addr) + ADDR_W'(step_words(up_q) * WORD_BYTES)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);

  assert_wb_end_offset_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && seq_done) |->
      (wb_q == acc_addr + ADDR_W'(end_off_words(pre_q, up_q) * WORD_BYTES)));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> ($stable(wb_q) && $stable(up_q)));

endmodule

// File: tb/lsm_addr_seq_bench.sv
module lsm_addr_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] reg_list = '0;
  logic        pre_index = 1'b0;
  logic        up = 1'b0;
  logic        acc_valid;
  logic [3:0]  acc_reg;
  logic [31:0] acc_addr;
  logic        seq_done;
  logic [31:0] wb_base;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lsm_addr_seq u_lsm_addr_seq (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .reg_list(reg_list), .pre_index(pre_index), .up(up),
    .acc_valid(acc_valid), .acc_reg(acc_reg), .acc_addr(acc_addr),
    .seq_done(seq_done), .wb_base(wb_base)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_seq(input logic [15:0] lst, input logic [31:0] base,
                         input logic pre, input logic dir, input int poke_at);
    int cnt = 0;
    int seen = 0;
    int fo;
    int st;
    logic [31:0] exp_addr;
    logic [31:0] exp_wb;
    for (int i = 0; i < 16; i++) cnt += int'(lst[i]);
    st = dir ? 4 : -4;
    fo = pre ? st : 0;
    exp_addr = base + 32'(fo);
    exp_wb   = base + 32'(st * cnt);
    @(negedge clk);
    start = 1'b1; base_addr = base; reg_list = lst; pre_index = pre; up = dir;
    @(negedge clk);
    start = 1'b0; base_addr = ~base; reg_list = ~lst; pre_index = ~pre; up = ~dir;
    if (cnt == 0) begin
      chk(acc_valid == 1'b0, "R7 valid", 32'(acc_valid), 32'd0);
      chk(seq_done == 1'b1, "R7 done", 32'(seq_done), 32'd1);
      chk(wb_base == base, "R7 wb", wb_base, base);
      @(negedge clk);
      chk(seq_done == 1'b0, "R7 done drop", 32'(seq_done), 32'd0);
      return;
    end
    for (int p = 0; p < 16; p++) begin
      int r;
      r = dir ? p : 15 - p;
      if (lst[r]) begin
        seen++;
        chk(acc_valid == 1'b1, "R2 valid", 32'(acc_valid), 32'd1);
        chk(acc_reg == 4'(r), "R2 order", 32'(acc_reg), 32'(r));
        chk(acc_addr == exp_addr, (seen == 1) ? "R3 first addr" : "R4 step addr", acc_addr, exp_addr);
        chk(seq_done == (seen == cnt), "R5 done", 32'(seq_done), 32'(seen == cnt));
        if (seen == cnt) chk(wb_base == exp_wb, "R6 wb", wb_base, exp_wb);
        if (seen == poke_at) begin
          start = 1'b1; base_addr = base ^ 32'h00F0_0000; reg_list = 16'hFFFF;
        end
        @(negedge clk);
        start = 1'b0;
        exp_addr = exp_addr + 32'(st);
      end
    end
    chk(acc_valid == 1'b0, "R5 valid after", 32'(acc_valid), 32'd0);
    chk(seq_done == 1'b0, "R5 done single", 32'(seq_done), 32'd0);
    chk(wb_base == exp_wb, (poke_at > 0) ? "R8 wb held" : "R6 wb held", wb_base, exp_wb);
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] x;
    logic [31:0] b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(acc_valid == 1'b0, "R1 valid", 32'(acc_valid), 32'd0);
    chk(seq_done == 1'b0, "R1 done", 32'(seq_done), 32'd0);
    chk(wb_base == 32'd0, "R1 wb", wb_base, 32'd0);
    b = 32'h2000_0100;
    for (int m = 0; m < 4; m++) begin
      logic pr, dr;
      pr = m[1]; dr = m[0];
      run_seq(16'h0000, b, pr, dr, 0);
      run_seq(16'hFFFF, b, pr, dr, 0);
      run_seq(16'h8001, 32'h0000_0000, pr, dr, 0);
      run_seq(16'h8000, 32'hFFFF_FFFC, pr, dr, 0);
      for (int i = 0; i < 16; i++) run_seq(16'(1) << i, b + 32'(i * 64), pr, dr, 0);
      for (int i = 0; i < 16; i++)
        for (int j = i + 1; j < 16; j++)
          run_seq((16'(1) << i) | (16'(1) << j), b ^ 32'(j * 16), pr, dr, 0);
      x = 16'h5A3C;
      for (int k = 0; k < 40; k++) begin
        x = x * 16'd25173 + 16'd13849;
        run_seq(x, b + 32'(k * 4096), pr, dr, (k % 4 == 0) ? 1 : 0);
      end
      run_seq(16'h0400, b, pr, dr, 1);   // R8 poke on a single-transfer done cycle
      run_seq(16'h1248, b, pr, dr, 2);   // R8 poke mid-sequence
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule